// File: doc/BRIEF.md
# Keyed Flash Program/Erase Controller

This block sits between a register bus and an on-chip nonvolatile word array. Software loads a target address, a data word and an operation code. It then writes a fixed three-word key and sets a start bit. The controller then runs either a single-word program or a whole-page erase on the array. It holds the start bit high as a busy indication until the work is finished.

Each of the four registers has three write views. A raw write replaces the contents. A set write ORs the written bits in. A clear write removes the written bits. The fourth view is unused. Low-voltage events during an operation and start attempts that break the rules are reported through sticky flags in the control register. A no-operation command that completes clears those flags.

The array side is a combinational read port and a one-word write port. A program operation can only turn ones into zeros. An erase sweeps one page, one word per cycle, writing all ones.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: A bus write selects its register with `bus_addr[3:2]` (0 control, 1 key, 2 address, 3 data) and its view with `bus_addr[1:0]` (0 replace, 1 OR-in, 2 AND-out of the written bits, 3 no effect). Reads through `rd_sel` use the same register numbers. The key register always reads 0.
- R2: The control register reads with the operation code in bits 3:0, busy in bit 15, write enable in bit 14, the write-error flag in bit 13 and the low-voltage flag in bit 12. All other bits read 0. After reset every register reads 0.
- R3: Three replace-view key writes of 0x00000000, 0xAA996655 and 0x556699AA, with no other key write between them, arm the controller. Any other key write breaks the sequence, and a value of 0 restarts it at its first step.
- R4: A write that sets bit 15 while idle starts an operation only if the controller is armed, write enable was already 1, and the new code is 0 (no-op), 1 (word program) or 4 (page erase). Any start attempt uses up the arming.
- R5: A start attempt that fails these tests leaves busy at 0, sets the write-error flag and leaves the array untouched.
- R6: A word program keeps busy high for WR_CYC+1 cycles. It changes the array word at index `addr[AW+1:2]` to its old value ANDed with the data register.
- R7: A page erase keeps busy high for ER_CYC+PAGE_WORDS cycles. It writes 0xFFFFFFFF to every word of the PAGE_WORDS-aligned page that holds the target word, and to no other word.
- R8: Busy clears by itself at the end of the operation. A program or erase that met no low-voltage event also clears write enable.
- R9: `lv_in` high in any busy cycle sets the low-voltage flag. If this happens during the wait phase, including its last cycle, nothing is written, busy ends after the wait phase, and write enable stays set. If it happens during the write phase, the write still completes.
- R10: An accepted no-op keeps busy high for one cycle. At its end it clears write enable, the write-error flag and the low-voltage flag.
- R11: While busy, writes to the control, address and data registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register select [3:2] and write view [1:0] |
| bus_wdata | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Selected register contents |
| lv_in | input | 1 | Low-voltage indication |
| arr_rd_addr | output | AW | Array read word index |
| arr_rd_data | input | 32 | Array read data |
| arr_wr_en | output | 1 | Array word write strobe |
| arr_wr_addr | output | AW | Array write word index |
| arr_wr_data | output | 32 | Array write data |

## Verification
The decision to skip the write can meet a low-voltage pulse in the same cycle. The wait phase ends on the edge where `lv_in` is sampled, so a pulse in the last wait cycle has to cancel the write, while a pulse one cycle later, in the first erase write cycle, must not. The bench places a one-cycle pulse at each of these two points. For the first it expects no array write, a shortened busy time, the low-voltage flag set and write enable still set. For the second it expects the whole page sweep and the flag set. The array writes are compared against a queue of expected writes.

// File: rtl/nvm_prog_pkg.sv
`timescale 1ns/1ps
package nvm_prog_pkg;
  localparam logic [31:0] KEY_STEP0 = 32'h0000_0000;
  localparam logic [31:0] KEY_STEP1 = 32'hAA99_6655;
  localparam logic [31:0] KEY_STEP2 = 32'h5566_99AA;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_WORD = 4'd1;
  localparam logic [3:0] OP_PAGE = 4'd4;

  localparam int BIT_BUSY  = 15;
  localparam int BIT_WREN  = 14;
  localparam int BIT_WRERR = 13;
  localparam int BIT_LVERR = 12;

  typedef enum logic [1:0] {REG_CTRL, REG_KEY, REG_ADDR, REG_DATA} reg_sel_e;
  typedef enum logic [1:0] {ALIAS_RAW, ALIAS_SET, ALIAS_CLR, ALIAS_NONE} alias_e;
  typedef enum logic [1:0] {E_IDLE, E_WAIT, E_COMMIT} eng_st_e;
  typedef enum logic [1:0] {KS_IDLE, KS_ONE, KS_TWO, KS_ARMED} key_st_e;

  function automatic logic [31:0] alias_w(logic [31:0] cur, logic [31:0] v, alias_e a);
    case (a)
      ALIAS_RAW: return v;
      ALIAS_SET: return cur | v;
      ALIAS_CLR: return cur & ~v;
      default:   return cur;
    endcase
  endfunction

  function automatic logic [3:0] alias_n4(logic [3:0] cur, logic [3:0] v, alias_e a);
    case (a)
      ALIAS_RAW: return v;
      ALIAS_SET: return cur | v;
      ALIAS_CLR: return cur & ~v;
      default:   return cur;
    endcase
  endfunction

  function automatic logic alias_b(logic cur, logic v, alias_e a);
    case (a)
      ALIAS_RAW: return v;
      ALIAS_SET: return cur | v;
      ALIAS_CLR: return cur & ~v;
      default:   return cur;
    endcase
  endfunction

  function automatic logic op_known(logic [3:0] op);
    return (op == OP_NOP) || (op == OP_WORD) || (op == OP_PAGE);
  endfunction
endpackage

// File: rtl/nvm_unlock_seq.sv
`timescale 1ns/1ps
module nvm_unlock_seq
  import nvm_prog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic        key_raw,
  input  logic [31:0] key_val,
  input  logic        consume,
  output logic        armed
);
  key_st_e st_q, st_d;

  // step taken by a key write in state s
  function automatic key_st_e key_step(key_st_e s, logic raw, logic [31:0] v);
    if (!raw) return KS_IDLE;
    case (s)
      KS_ONE:  return (v == KEY_STEP1) ? KS_TWO : ((v == KEY_STEP0) ? KS_ONE : KS_IDLE);
      KS_TWO:  return (v == KEY_STEP2) ? KS_ARMED : ((v == KEY_STEP0) ? KS_ONE : KS_IDLE);
      default: return (v == KEY_STEP0) ? KS_ONE : KS_IDLE;
    endcase
  endfunction

  always_comb begin
    st_d = st_q;
    if (key_wr)       st_d = key_step(st_q, key_raw, key_val);
    else if (consume) st_d = KS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == KS_ARMED);

  // R3
  armed_by_last_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(key_wr && key_raw && key_val == KEY_STEP2));
endmodule

// File: rtl/nvm_op_engine.sv
`timescale 1ns/1ps
module nvm_op_engine
  import nvm_prog_pkg::*;
#(
  parameter int AW         = 8,
  parameter int PAGE_WORDS = 16,
  parameter int WR_CYC     = 4,
  parameter int ER_CYC     = 6
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic [AW-1:0] tgt_widx,
  input  logic [31:0]   wdata,
  input  logic          lv_in,
  output logic          busy,
  output logic          lv_evt,
  output logic          done,
  output logic          done_ok,
  output logic [AW-1:0] arr_rd_addr,
  input  logic [31:0]   arr_rd_data,
  output logic          arr_wr_en,
  output logic [AW-1:0] arr_wr_addr,
  output logic [31:0]   arr_wr_data
);
  localparam int PW   = $clog2(PAGE_WORDS);
  localparam int MAXC = (WR_CYC > ER_CYC) ? WR_CYC : ER_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  eng_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] idx_q;
  logic [3:0]    op_q;
  logic          lv_seen_q;

  function automatic logic [CW-1:0] wait_len(logic [3:0] o);
    case (o)
      OP_WORD: return CW'(WR_CYC);
      OP_PAGE: return CW'(ER_CYC);
      default: return CW'(1);
    endcase
  endfunction

  logic wait_last, skip, is_erase, last_commit;
  assign wait_last   = (st_q == E_WAIT) && (cnt_q == CW'(1));
  assign skip        = lv_seen_q || lv_in;
  assign is_erase    = (op_q == OP_PAGE);
  assign last_commit = (st_q == E_COMMIT) && (!is_erase || idx_q == PW'(PAGE_WORDS - 1));

  assign busy    = (st_q != E_IDLE);
  assign lv_evt  = busy && lv_in;
  assign done    = (wait_last && (op_q == OP_NOP || skip)) || last_commit;
  assign done_ok = !skip;

  assign arr_rd_addr = tgt_widx;
  assign arr_wr_en   = (st_q == E_COMMIT);
  assign arr_wr_addr = is_erase ? {tgt_widx[AW-1:PW], idx_q} : tgt_widx;
  assign arr_wr_data = is_erase ? 32'hFFFF_FFFF : (arr_rd_data & wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= E_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      op_q      <= OP_NOP;
      lv_seen_q <= 1'b0;
    end else begin
      case (st_q)
        E_IDLE: if (start) begin
          st_q      <= E_WAIT;
          cnt_q     <= wait_len(op);
          idx_q     <= '0;
          op_q      <= op;
          lv_seen_q <= 1'b0;
        end
        E_WAIT: begin
          if (lv_in) lv_seen_q <= 1'b1;
          if (wait_last) st_q <= (op_q == OP_NOP || skip) ? E_IDLE : E_COMMIT;
          else           cnt_q <= cnt_q - CW'(1);
        end
        E_COMMIT: begin
          if (lv_in) lv_seen_q <= 1'b1;
          if (last_commit) st_q <= E_IDLE;
          else             idx_q <= idx_q + PW'(1);
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  // R9
  clean_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_wr_en) |-> !$past(lv_in));
  // R7
  erase_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_en && is_erase && idx_q != '0) |-> (arr_wr_addr == $past(arr_wr_addr) + AW'(1)));
endmodule

// File: rtl/nvm_prog_ctrl.sv
`timescale 1ns/1ps
module nvm_prog_ctrl
  import nvm_prog_pkg::*;
#(
  parameter int AW         = 8,
  parameter int PAGE_WORDS = 16,
  parameter int WR_CYC     = 4,
  parameter int ER_CYC     = 6
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [3:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic [1:0]    rd_sel,
  output logic [31:0]   rd_data,
  input  logic          lv_in,
  output logic [AW-1:0] arr_rd_addr,
  input  logic [31:0]   arr_rd_data,
  output logic          arr_wr_en,
  output logic [AW-1:0] arr_wr_addr,
  output logic [31:0]   arr_wr_data
);
  localparam int WIDX_LO = 2;

  reg_sel_e wr_sel;
  alias_e   wr_al;
  assign wr_sel = reg_sel_e'(bus_addr[3:2]);
  assign wr_al  = alias_e'(bus_addr[1:0]);

  logic [3:0]  op_q;
  logic        wren_q, wrerr_q, lverr_q;
  logic [31:0] addr_q, data_q;
  logic        busy, lv_evt, done, done_ok, armed;

  logic wr_eff, ctrl_wr, key_wr, key_raw;
  assign wr_eff  = bus_wr && (wr_al != ALIAS_NONE);
  assign ctrl_wr = wr_eff && (wr_sel == REG_CTRL) && !busy;
  assign key_wr  = wr_eff && (wr_sel == REG_KEY);
  assign key_raw = (wr_al == ALIAS_RAW);

  logic [3:0] new_op;
  logic       new_wren, new_go;
  assign new_op   = alias_n4(op_q, bus_wdata[3:0], wr_al);
  assign new_wren = alias_b(wren_q, bus_wdata[BIT_WREN], wr_al);
  assign new_go   = alias_b(1'b0, bus_wdata[BIT_BUSY], wr_al);

  logic start_try, start_ok, start_bad;
  assign start_try = ctrl_wr && new_go;
  assign start_ok  = start_try && armed && wren_q && op_known(new_op);
  assign start_bad = start_try && !start_ok;

  nvm_unlock_seq u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (key_wr),
    .key_raw (key_raw),
    .key_val (bus_wdata),
    .consume (start_try),
    .armed   (armed)
  );

  nvm_op_engine #(
    .AW(AW), .PAGE_WORDS(PAGE_WORDS), .WR_CYC(WR_CYC), .ER_CYC(ER_CYC)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_ok),
    .op          (new_op),
    .tgt_widx    (addr_q[AW+WIDX_LO-1:WIDX_LO]),
    .wdata       (data_q),
    .lv_in       (lv_in),
    .busy        (busy),
    .lv_evt      (lv_evt),
    .done        (done),
    .done_ok     (done_ok),
    .arr_rd_addr (arr_rd_addr),
    .arr_rd_data (arr_rd_data),
    .arr_wr_en   (arr_wr_en),
    .arr_wr_addr (arr_wr_addr),
    .arr_wr_data (arr_wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NOP;
      wren_q  <= 1'b0;
      wrerr_q <= 1'b0;
      lverr_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        op_q   <= new_op;
        wren_q <= new_wren;
      end
      if (start_bad) wrerr_q <= 1'b1;
      if (lv_evt)    lverr_q <= 1'b1;
      if (done) begin
        if (op_q == OP_NOP) begin
          wren_q  <= 1'b0;
          wrerr_q <= 1'b0;
          lverr_q <= 1'b0;
        end else if (done_ok) begin
          wren_q <= 1'b0;
        end
      end
      if (wr_eff && !busy && wr_sel == REG_ADDR) addr_q <= alias_w(addr_q, bus_wdata, wr_al);
      if (wr_eff && !busy && wr_sel == REG_DATA) data_q <= alias_w(data_q, bus_wdata, wr_al);
    end
  end

  logic [31:0] ctrl_view;
  always_comb begin
    ctrl_view            = '0;
    ctrl_view[3:0]       = op_q;
    ctrl_view[BIT_BUSY]  = busy;
    ctrl_view[BIT_WREN]  = wren_q;
    ctrl_view[BIT_WRERR] = wrerr_q;
    ctrl_view[BIT_LVERR] = lverr_q;
  end

  always_comb begin
    case (reg_sel_e'(rd_sel))
      REG_CTRL: rd_data = ctrl_view;
      REG_ADDR: rd_data = addr_q;
      REG_DATA: rd_data = data_q;
      default:  rd_data = '0;
    endcase
  end

  // R4
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy);
  // R4
  arm_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_try |=> !armed);
  // R5
  reject_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (wrerr_q && !busy));
  // R8
  busy_ends_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  // R11
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q));
endmodule

// File: tb/sim_nvm_prog_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_prog_ctrl;
  import nvm_prog_pkg::*;
  localparam int AW = 8, PW = 16, WRC = 4, ERC = 6;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          bus_wr = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [1:0]    rd_sel = '0;
  logic [31:0]   rd_data;
  logic          lv_in = 1'b0;
  logic [AW-1:0] arr_rd_addr, arr_wr_addr;
  logic [31:0]   arr_rd_data, arr_wr_data;
  logic          arr_wr_en;

  logic [31:0] mem [0:NW-1];
  logic [31:0] mdl [0:NW-1];

  nvm_prog_ctrl #(.AW(AW), .PAGE_WORDS(PW), .WR_CYC(WRC), .ER_CYC(ERC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_sel(rd_sel), .rd_data(rd_data), .lv_in(lv_in),
    .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data), .arr_wr_en(arr_wr_en),
    .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data)
  );

  assign arr_rd_data = mem[arr_rd_addr];
  always @(posedge clk) if (arr_wr_en) mem[arr_wr_addr] <= arr_wr_data;

  typedef struct packed { logic [AW-1:0] a; logic [31:0] d; } wr_item_t;
  wr_item_t exp_q[$];
  wr_item_t mon_it;
  int n_chk = 0, n_fail = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: every array write must match the next expected item
  always @(negedge clk) begin
    if (rst_n && arr_wr_en) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5/R9 stray array write: got %h@%0d expected none", arr_wr_data, arr_wr_addr);
      end else begin
        mon_it = exp_q.pop_front();
        if ({arr_wr_addr, arr_wr_data} !== {mon_it.a, mon_it.d}) begin
          n_fail++;
          $display("FAIL R6/R7 array write: got %h@%0d expected %h@%0d",
                   arr_wr_data, arr_wr_addr, mon_it.d, mon_it.a);
        end
      end
    end
  end

  function automatic logic [3:0] ra(reg_sel_e s, alias_e a);
    return {s, a};
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(reg_sel_e s, output logic [31:0] d);
    rd_sel = s;
    #1 d = rd_data;
  endtask

  task automatic unlock();
    wr(ra(REG_KEY, ALIAS_RAW), KEY_STEP0);
    wr(ra(REG_KEY, ALIAS_RAW), KEY_STEP1);
    wr(ra(REG_KEY, ALIAS_RAW), KEY_STEP2);
  endtask

  // driver side of the scoreboard
  task automatic exp_word(int w, logic [31:0] d);
    mdl[w] = mdl[w] & d;
    exp_q.push_back('{a: AW'(w), d: mdl[w]});
  endtask

  task automatic exp_erase(int w);
    int base;
    base = (w / PW) * PW;
    for (int i = 0; i < PW; i++) begin
      mdl[base + i] = 32'hFFFF_FFFF;
      exp_q.push_back('{a: AW'(base + i), d: 32'hFFFF_FFFF});
    end
  endtask

  // start, then count busy cycles; optional lv pulse in busy cycle lv_at
  task automatic go(int lv_at, output int cyc);
    logic [31:0] v;
    wr(ra(REG_CTRL, ALIAS_SET), 32'h0000_8000);
    cyc = 0;
    forever begin
      rd(REG_CTRL, v);
      if (!v[BIT_BUSY] || cyc > 1000) break;
      cyc++;
      lv_in = (cyc == lv_at);
      @(negedge clk);
    end
    lv_in = 1'b0;
  endtask

  task automatic recover();
    int c;
    logic [31:0] v;
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0000_4000);
    unlock();
    go(0, c);
    rd(REG_CTRL, v);
    check("R10 no-op recovery clears flags", v, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c;
    for (int i = 0; i < NW; i++) begin
      mem[i] = 32'hFFFF_FFFF;
      mdl[i] = 32'hFFFF_FFFF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset values
    rd(REG_CTRL, v); check("R2 reset ctrl", v, 32'h0);
    rd(REG_ADDR, v); check("R2 reset addr", v, 32'h0);

    // R1 write views
    wr(ra(REG_ADDR, ALIAS_RAW), 32'h0000_00F0);
    wr(ra(REG_ADDR, ALIAS_SET), 32'h0000_000F);
    rd(REG_ADDR, v); check("R1 set view", v, 32'h0000_00FF);
    wr(ra(REG_ADDR, ALIAS_CLR), 32'h0000_00F0);
    rd(REG_ADDR, v); check("R1 clear view", v, 32'h0000_000F);
    wr(ra(REG_ADDR, ALIAS_NONE), 32'hFFFF_FFFF);
    rd(REG_ADDR, v); check("R1 unused view", v, 32'h0000_000F);
    wr(ra(REG_KEY, ALIAS_RAW), 32'h0000_1234);
    rd(REG_KEY, v); check("R1 key reads zero", v, 32'h0);

    // R2 layout, undefined bits dropped
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0F00_4FF1);
    rd(REG_CTRL, v); check("R2 ctrl layout", v, 32'h0000_4001);

    // R5 start without unlock
    wr(ra(REG_CTRL, ALIAS_SET), 32'h0000_8000);
    rd(REG_CTRL, v); check("R5 start without key", v, 32'h0000_6001);

    // R10 no-op
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0000_4000);
    unlock(); go(0, c);
    check("R10 no-op busy length", c, 1);
    rd(REG_CTRL, v); check("R10 no-op clears", v, 32'h0);

    // R6 word programs
    wr(ra(REG_ADDR, ALIAS_RAW), 32'h40);
    wr(ra(REG_DATA, ALIAS_RAW), 32'h1234_5678);
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0000_4001);
    exp_word(16, 32'h1234_5678);
    unlock(); go(0, c);
    check("R6 program busy length", c, WRC + 1);
    rd(REG_CTRL, v); check("R8 wren cleared after program", v, 32'h0000_0001);
    check("R6 programmed word", mem[16], 32'h1234_5678);
    wr(ra(REG_DATA, ALIAS_RAW), 32'hFFFF_00FF);
    wr(ra(REG_CTRL, ALIAS_SET), 32'h0000_4000);
    exp_word(16, 32'hFFFF_00FF);
    unlock(); go(0, c);
    check("R6 program only clears bits", mem[16], 32'h1234_0078);
    wr(ra(REG_ADDR, ALIAS_RAW), 32'h80);
    wr(ra(REG_DATA, ALIAS_RAW), 32'hA5A5_A5A5);
    wr(ra(REG_CTRL, ALIAS_SET), 32'h0000_4000);
    exp_word(32, 32'hA5A5_A5A5);
    unlock(); go(0, c);
    wr(ra(REG_ADDR, ALIAS_RAW), 32'h3C);
    wr(ra(REG_DATA, ALIAS_RAW), 32'h0000_FFFF);
    wr(ra(REG_CTRL, ALIAS_SET), 32'h0000_4000);
    exp_word(15, 32'h0000_FFFF);
    unlock(); go(0, c);

    // R7 page erase
    wr(ra(REG_ADDR, ALIAS_RAW), 32'h48);
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0000_4004);
    exp_erase(18);
    unlock(); go(0, c);
    check("R7 erase busy length", c, ERC + PW);
    check("R7 page word erased", mem[16], 32'hFFFF_FFFF);
    check("R7 next page untouched", mem[32], 32'hA5A5_A5A5);
    check("R7 previous page untouched", mem[15], 32'h0000_FFFF);
    rd(REG_CTRL, v); check("R8 wren cleared after erase", v, 32'h0000_0004);

    // R3 broken key sequence
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0000_4001);
    wr(ra(REG_KEY, ALIAS_RAW), KEY_STEP0);
    wr(ra(REG_KEY, ALIAS_RAW), KEY_STEP1);
    wr(ra(REG_KEY, ALIAS_RAW), 32'h0000_1234);
    wr(ra(REG_KEY, ALIAS_RAW), KEY_STEP2);
    wr(ra(REG_CTRL, ALIAS_SET), 32'h0000_8000);
    rd(REG_CTRL, v); check("R3 broken sequence rejected", v, 32'h0000_6001);
    recover();
    // R3 zero restarts the sequence
    wr(ra(REG_ADDR, ALIAS_RAW), 32'h44);
    wr(ra(REG_DATA, ALIAS_RAW), 32'h0F0F_0F0F);
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0000_4001);
    exp_word(17, 32'h0F0F_0F0F);
    wr(ra(REG_KEY, ALIAS_RAW), KEY_STEP0);
    wr(ra(REG_KEY, ALIAS_RAW), KEY_STEP0);
    wr(ra(REG_KEY, ALIAS_RAW), KEY_STEP1);
    wr(ra(REG_KEY, ALIAS_RAW), KEY_STEP2);
    go(0, c);
    check("R3 restarted sequence accepted", c, WRC + 1);
    check("R3 restarted program result", mem[17], 32'h0F0F_0F0F);

    // R4 arming used up
    wr(ra(REG_CTRL, ALIAS_SET), 32'h0000_4000);
    wr(ra(REG_CTRL, ALIAS_SET), 32'h0000_8000);
    rd(REG_CTRL, v); check("R4 arming consumed", v, 32'h0000_6001);
    recover();

    // R4 write enable not set beforehand
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0000_0001);
    unlock();
    wr(ra(REG_CTRL, ALIAS_SET), 32'h0000_8000);
    rd(REG_CTRL, v); check("R4 start needs write enable", v, 32'h0000_2001);
    recover();

    // R4 unknown operation code
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0000_4002);
    unlock();
    wr(ra(REG_CTRL, ALIAS_SET), 32'h0000_8000);
    rd(REG_CTRL, v); check("R4 unknown code rejected", v, 32'h0000_6002);
    recover();

    // R9 low voltage in last wait cycle: no write
    wr(ra(REG_ADDR, ALIAS_RAW), 32'h50);
    wr(ra(REG_DATA, ALIAS_RAW), 32'h0);
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0000_4001);
    unlock(); go(WRC, c);
    check("R9 skipped program busy length", c, WRC);
    rd(REG_CTRL, v); check("R9 flag set, wren kept", v, 32'h0000_5001);
    check("R9 word untouched", mem[20], 32'hFFFF_FFFF);
    recover();

    // R9 low voltage in first erase write cycle: erase completes
    wr(ra(REG_ADDR, ALIAS_RAW), 32'h48);
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0000_4004);
    exp_erase(18);
    unlock(); go(ERC + 1, c);
    check("R9 late pulse erase length", c, ERC + PW);
    rd(REG_CTRL, v); check("R9 late pulse flag", v, 32'h0000_5004);
    check("R9 late pulse erase done", mem[17], 32'hFFFF_FFFF);
    recover();

    // R11 writes ignored while busy
    wr(ra(REG_ADDR, ALIAS_RAW), 32'h60);
    wr(ra(REG_DATA, ALIAS_RAW), 32'h00FF_FFFF);
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0000_4001);
    exp_word(24, 32'h00FF_FFFF);
    unlock();
    wr(ra(REG_CTRL, ALIAS_SET), 32'h0000_8000);
    wr(ra(REG_ADDR, ALIAS_RAW), 32'h70);
    wr(ra(REG_CTRL, ALIAS_RAW), 32'h0000_4004);
    repeat (WRC + 4) @(negedge clk);
    rd(REG_ADDR, v); check("R11 addr write ignored while busy", v, 32'h60);
    rd(REG_CTRL, v); check("R11 ctrl write ignored while busy", v, 32'h0000_0001);
    check("R11 program used original target", mem[24], 32'h00FF_FFFF);

    repeat (4) @(negedge clk);
    check("R6/R7 all expected writes seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule